// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a synchronous DRAM from reset until the memory can accept normal traffic. Once reset is released, it drives NOP and waits until a clock-stable input has stayed high for a programmable number of cycles. It then issues a precharge to all banks and two auto-refresh commands. Last, it issues a load of the mode register, with a word assembled from input fields. A fixed minimum gap separates each command from the next, and the block drives NOP in every cycle between them.

When the gap after the mode load has expired, a ready flag rises and stays high, and the sequencer keeps the bus at NOP so that the main controller can take it over. If the clock-stable input drops at any time before ready, the sequencer goes back to the start and begins the power-up wait again from zero.

All delays are parameters counted in clock cycles: the power-up wait, the precharge-to-command gap, the refresh-to-command gap and the mode-load-to-command gap.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After reset, the outputs show NOP ({cs_n,ras_n,cas_n,we_n}=0111) with ready low. They stay that way until clk_stable has been sampled high on WAIT_CYC consecutive rising edges. The cycle after the WAIT_CYC-th such edge shows the precharge.
- R2: The precharge is encoded 0010 with address bit 10 set, all other address bits 0 and bank address 0. It lasts exactly one cycle.
- R3: The first auto-refresh (0001, address and bank 0) appears TRP_CYC cycles after the precharge. The second appears TRFC_CYC cycles after the first. Exactly two auto-refreshes are issued per sequence.
- R4: The mode load (0000, bank address 0) appears TRFC_CYC cycles after the second auto-refresh.
- R5: The address during the mode load has the following layout:
  - bits 2:0 carry the burst length.
  - bit 3 carries the burst type.
  - bits 6:4 carry the CAS latency.
  - bits 8:7 carry the operating mode.
  - bit 9 carries the write burst mode.
  - bit 10 and all higher bits are 0.
- R6: Every command lasts one cycle, and every cycle between commands before ready is NOP with address and bank address 0.
- R7: ready rises TMRD_CYC cycles after the mode load cycle. From then on it stays high with NOP on the bus until reset.
- R8: If clk_stable is sampled low on any edge before ready, the next cycle shows NOP, and the full WAIT_CYC count restarts from zero. After ready, clk_stable has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_stable | input | 1 | High while the memory clock is within its limits |
| mode_burst_len | input | 3 | Burst length field of the mode word |
| mode_burst_type | input | 1 | Burst type field of the mode word |
| mode_cas_lat | input | 3 | CAS latency field of the mode word |
| mode_op | input | 2 | Operating mode field of the mode word |
| mode_wr_burst | input | 1 | Write burst mode field of the mode word |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | High once the sequence has completed |

## Verification
The checker watches several rules on every cycle:
- Every command is followed by a NOP.
- Address bit 10 is set during the precharge, and the bits at and above it are clear during the mode load.
- A mode load is preceded by exactly two refreshes since the last precharge.
- ready is sticky and comes exactly TMRD_CYC cycles after the mode load.
- A clock-stable drop before ready is followed by NOP.

Only the bench's scenarios can show two further properties. The first is that the exact cycle distances from the stable point to each command are right. The second is that an abort really restarts the full wait instead of resuming it. The bench shows these by checking random mode words and random abort points against a cycle-indexed model.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdram_cmd_e;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_PRE,
      ST_TRP,
      ST_REF,
      ST_TRFC,
      ST_LMR,
      ST_TMRD,
      ST_READY
   } seq_state_e;

   // packed so that blen lands in bits 2:0 and wr_burst in bit 9
   typedef struct packed {
      logic       wr_burst;
      logic [1:0] op;
      logic [2:0] cas;
      logic       btype;
      logic [2:0] blen;
   } mode_fields_t;

   localparam int MODE_FIELD_W = 10;

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
   parameter int              CNT_W   = 8,
   parameter logic [CNT_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_pwrup_mode_word.sv
module sdram_pwrup_mode_word
   import sdram_pwrup_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  mode_fields_t      fields,
   output logic [ADDR_W-1:0] word
);

   localparam int PAD_W = ADDR_W - MODE_FIELD_W;

   generate
      if (PAD_W > 0) begin : g_pad
         assign word = {{PAD_W{1'b0}}, fields};
      end else begin : g_exact
         assign word = fields;
      end
   endgenerate

endmodule

// File: rtl/sdram_pwrup_cmd_drv.sv
module sdram_pwrup_cmd_drv
   import sdram_pwrup_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int BA_W   = 2,
   parameter int AP_BIT = 10
) (
   input  seq_state_e        state,
   input  logic [ADDR_W-1:0] mode_word,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

   sdram_cmd_e cmd;

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      unique case (state)
         ST_PRE: begin
            cmd  = CMD_PRE;
            addr = ALL_BANKS;
         end
         ST_REF: cmd = CMD_REF;
         ST_LMR: begin
            cmd  = CMD_LMR;
            addr = mode_word;
         end
         default: begin
            cmd  = CMD_NOP;
            addr = '0;
         end
      endcase
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign ba = '0;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_pwrup_pkg::*;
#(
   parameter int WAIT_CYC = 10000,
   parameter int TRP_CYC  = 3,
   parameter int TRFC_CYC = 7,
   parameter int TMRD_CYC = 2,
   parameter int ADDR_W   = 12,
   parameter int BA_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_stable,
   input  logic [2:0]        mode_burst_len,
   input  logic              mode_burst_type,
   input  logic [2:0]        mode_cas_lat,
   input  logic [1:0]        mode_op,
   input  logic              mode_wr_burst,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              ready
);

   localparam int NUM_REF  = 2;
   localparam int AP_BIT   = 10;
   localparam int GAP_MAX  = (TRP_CYC > TRFC_CYC) ?
                             ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC) :
                             ((TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC);
   localparam int CYC_MAX  = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
   localparam int CNT_W    = $clog2(CYC_MAX + 1);
   localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] TRP_LD  = CNT_W'(TRP_CYC - 2);
   localparam logic [CNT_W-1:0] TRFC_LD = CNT_W'(TRFC_CYC - 2);
   localparam logic [CNT_W-1:0] TMRD_LD = CNT_W'(TMRD_CYC - 2);

   // elaboration-time parameter checks
   generate
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("WAIT_CYC must be at least 1");
      end
      if ((TRP_CYC < 2) || (TRFC_CYC < 2) || (TMRD_CYC < 2)) begin : g_bad_gap
         $error("command gaps must be at least 2 cycles");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W must be at least 12");
      end
      if (BA_W < 1) begin : g_bad_ba
         $error("BA_W must be at least 1");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic [1:0]       ref_q, ref_d;
   logic             tmr_load, tmr_dec, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic [ADDR_W-1:0] mode_word;
   mode_fields_t     fields;

   assign fields = '{wr_burst: mode_wr_burst, op: mode_op, cas: mode_cas_lat,
                     btype: mode_burst_type, blen: mode_burst_len};

   sdram_pwrup_mode_word #(.ADDR_W(ADDR_W)) u_mode (
      .fields (fields),
      .word   (mode_word)
   );

   sdram_pwrup_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_LD)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .dec      (tmr_dec),
      .zero     (tmr_zero)
   );

   always_comb begin
      state_d  = state_q;
      ref_d    = ref_q;
      tmr_load = 1'b0;
      tmr_dec  = 1'b0;
      tmr_val  = WAIT_LD;
      if ((state_q != ST_READY) && !clk_stable) begin
         state_d  = ST_WAIT;
         ref_d    = '0;
         tmr_load = 1'b1;
         tmr_val  = WAIT_LD;
      end else begin
         unique case (state_q)
            ST_WAIT: begin
               if (tmr_zero) state_d = ST_PRE;
               else          tmr_dec = 1'b1;
            end
            ST_PRE: begin
               state_d  = ST_TRP;
               tmr_load = 1'b1;
               tmr_val  = TRP_LD;
            end
            ST_TRP: begin
               if (tmr_zero) state_d = ST_REF;
               else          tmr_dec = 1'b1;
            end
            ST_REF: begin
               state_d  = ST_TRFC;
               ref_d    = ref_q + 2'd1;
               tmr_load = 1'b1;
               tmr_val  = TRFC_LD;
            end
            ST_TRFC: begin
               if (tmr_zero) state_d = (ref_q == 2'(NUM_REF)) ? ST_LMR : ST_REF;
               else          tmr_dec = 1'b1;
            end
            ST_LMR: begin
               state_d  = ST_TMRD;
               tmr_load = 1'b1;
               tmr_val  = TMRD_LD;
            end
            ST_TMRD: begin
               if (tmr_zero) state_d = ST_READY;
               else          tmr_dec = 1'b1;
            end
            default: state_d = ST_READY;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         ref_q   <= '0;
      end else begin
         state_q <= state_d;
         ref_q   <= ref_d;
      end
   end

   sdram_pwrup_cmd_drv #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_drv (
      .state     (state_q),
      .mode_word (mode_word),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .ba        (ba),
      .addr      (addr)
   );

   assign ready = (state_q == ST_READY);

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
   parameter int TMRD_CYC = 2,
   parameter int ADDR_W   = 12,
   parameter int BA_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_stable,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BA_W-1:0]   ba,
   input logic [ADDR_W-1:0] addr,
   input logic              ready
);

   logic [3:0] cmd;
   logic       is_nop, is_pre, is_ref, is_lmr;
   logic [1:0] refs_seen;
   int         since_lmr;

   assign cmd    = {cs_n, ras_n, cas_n, we_n};
   assign is_nop = (cmd == 4'b0111);
   assign is_pre = (cmd == 4'b0010);
   assign is_ref = (cmd == 4'b0001);
   assign is_lmr = (cmd == 4'b0000);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         refs_seen <= '0;
         since_lmr <= 0;
      end else begin
         if (is_pre)                         refs_seen <= '0;
         else if (is_ref && refs_seen != 2'd3) refs_seen <= refs_seen + 2'd1;
         if (is_lmr)                         since_lmr <= 1;
         else if (since_lmr != 0 && since_lmr < TMRD_CYC + 4) since_lmr <= since_lmr + 1;
      end
   end

   p_cmd_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !is_nop |=> is_nop);
   p_pre_all_banks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> (addr[10] && ba == '0));
   p_lmr_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_lmr |-> (addr[ADDR_W-1:10] == '0 && ba == '0));
   p_two_refs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_lmr |-> (refs_seen == 2'd2));
   p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);
   p_ready_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> is_nop);
   p_ready_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (since_lmr == TMRD_CYC));
   p_abort_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !clk_stable) |=> is_nop);

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
   .TMRD_CYC (TMRD_CYC),
   .ADDR_W   (ADDR_W),
   .BA_W     (BA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_stable (clk_stable),
   .cs_n       (cs_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .ba         (ba),
   .addr       (addr),
   .ready      (ready)
);

// File: tb/sdram_pwrup_seq_test.sv
module sdram_pwrup_seq_test;

   localparam int WAIT_CYC = 20;
   localparam int TRP_CYC  = 3;
   localparam int TRFC_CYC = 5;
   localparam int TMRD_CYC = 2;
   localparam int ADDR_W   = 12;
   localparam int BA_W     = 2;
   localparam int T_PRE  = WAIT_CYC;
   localparam int T_REF1 = T_PRE + TRP_CYC;
   localparam int T_REF2 = T_REF1 + TRFC_CYC;
   localparam int T_LMR  = T_REF2 + TRFC_CYC;
   localparam int T_RDY  = T_LMR + TMRD_CYC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_stable = 1'b0;
   logic [2:0] m_bl = '0;
   logic       m_bt = 1'b0;
   logic [2:0] m_cl = '0;
   logic [1:0] m_op = '0;
   logic       m_wb = 1'b0;
   logic cs_n, ras_n, cas_n, we_n, ready;
   logic [BA_W-1:0]   ba;
   logic [ADDR_W-1:0] addr;

   int n_chk = 0;
   int n_bad = 0;
   int k = 0;
   bit done_exp = 1'b0;
   bit aborted = 1'b0;
   bit wd_hit = 1'b0;

   always #5 clk = ~clk;

   sdram_pwrup_seq #(
      .WAIT_CYC(WAIT_CYC), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC),
      .TMRD_CYC(TMRD_CYC), .ADDR_W(ADDR_W), .BA_W(BA_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
      .mode_burst_len(m_bl), .mode_burst_type(m_bt), .mode_cas_lat(m_cl),
      .mode_op(m_op), .mode_wr_burst(m_wb),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .ready(ready)
   );

   function automatic logic [3:0] exp_cmd(int kk, bit rdy);
      if (rdy)         return 4'b0111;
      if (kk == T_PRE) return 4'b0010;
      if (kk == T_REF1 || kk == T_REF2) return 4'b0001;
      if (kk == T_LMR) return 4'b0000;
      return 4'b0111;
   endfunction

   function automatic logic [ADDR_W-1:0] exp_addr(int kk, bit rdy);
      if (rdy)         return '0;
      if (kk == T_PRE) return ADDR_W'(1) << 10;
      if (kk == T_LMR) return ADDR_W'({m_wb, m_op, m_cl, m_bt, m_bl});
      return '0;
   endfunction

   function automatic string tag_of(int kk, bit rdy, bit ab);
      if (rdy)          return ab ? "R8" : "R7";
      if (kk == T_PRE)  return "R2";
      if (kk == T_REF1 || kk == T_REF2) return "R3";
      if (kk == T_LMR)  return "R4/R5";
      if (kk < T_PRE)   return ab ? "R8" : "R1";
      return "R6";
   endfunction

   // sample after negedge: compare every output to the model
   task automatic check_now();
      logic [3:0]        c_e;
      logic [ADDR_W-1:0] a_e;
      c_e = exp_cmd(k, done_exp);
      a_e = exp_addr(k, done_exp);
      n_chk++;
      if ({cs_n, ras_n, cas_n, we_n} !== c_e || addr !== a_e || ba !== '0 ||
          ready !== done_exp) begin
         n_bad++;
         $display("FAIL %s k=%0d: cmd=%b addr=%h ba=%0d ready=%b expected cmd=%b addr=%h ba=0 ready=%b",
                  tag_of(k, done_exp, aborted), k, {cs_n, ras_n, cas_n, we_n}, addr, ba, ready,
                  c_e, a_e, done_exp);
      end
   endtask

   // apply clk_stable for the next edge, advance the model, then check
   task automatic step(bit stable);
      clk_stable = stable;
      @(posedge clk);
      if (!done_exp) begin
         if (stable) k++;
         else begin
            k = 0;
            aborted = 1'b1;
         end
         if (k == T_RDY) done_exp = 1'b1;
      end else if (!stable) aborted = 1'b1;
      @(negedge clk);
      check_now();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      clk_stable = 1'b0;
      k = 0;
      done_exp = 1'b0;
      aborted = 1'b0;
      repeat (2) @(negedge clk);
      check_now(); // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic rand_mode();
      m_bl = 3'($urandom);
      m_bt = 1'($urandom);
      m_cl = 3'($urandom);
      m_op = 2'($urandom);
      m_wb = 1'($urandom);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      wd_hit = 1'b1;
   end

   initial begin
      void'($urandom(32'd1234));

      // directed: R1 wait held off while unstable, then a clean run (R2-R7)
      m_bl = 3'b111; m_bt = 1'b1; m_cl = 3'b101; m_op = 2'b11; m_wb = 1'b1;
      do_reset();
      for (int i = 0; i < 6; i++) step(1'b0);
      for (int i = 0; i < T_RDY + 4; i++) step(1'b1);
      // R8: clk_stable ignored after ready
      for (int i = 0; i < 5; i++) step(1'b0);
      for (int i = 0; i < 3; i++) step(1'b1);

      // directed: abort one cycle before PRE and right at LMR (R8)
      rand_mode();
      do_reset();
      for (int i = 0; i < T_PRE - 1; i++) step(1'b1);
      step(1'b0);
      for (int i = 0; i < T_LMR; i++) step(1'b1);
      step(1'b0);
      for (int i = 0; i < T_RDY + 3; i++) step(1'b1);

      // random: mode words, abort points and drop lengths
      for (int run = 0; run < 60 && !wd_hit; run++) begin
         rand_mode();
         do_reset();
         for (int c = 0; c < 4 * T_RDY && !wd_hit; c++) begin
            step(($urandom % 40) != 0);
         end
         for (int c = 0; c < T_RDY + 2; c++) step(1'b1);
      end

      if (wd_hit) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual=expired expected=finished");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule